// File: doc/BRIEF.md
# Synchronous Burst Memory Access Sequencer

This block is the device side of a synchronous burst memory. Commands arrive on a 3-bit command bus and are registered on the rising clock edge. A mode word, loaded by a dedicated command, sets several things:

- the burst length;
- the order in which addresses are visited inside a burst;
- the read latency;
- an operating-mode field;
- the policy for write bursts.

For every READ or WRITE the sequencer walks the column addresses of the burst, one per cycle. It shows each address on `col_o`, combinationally, in the cycle its beat takes place. Write beats store `wdata_i` into a small internal register file. Read beats fetch a word and deliver it after the programmed latency. The output-enable strobe turns on one cycle ahead of the first valid word.

A burst can be cut short by a terminate command or by a new access. A mode word with a reserved field is flagged, and accesses are refused while it stays in place. A mode load is honoured only when nothing is in flight.

Top module: `burst_seq`

## Requirements
- R1: Command encoding on `cmd_i`: 0 NOP, 1 READ, 2 WRITE, 3 LOAD, 4 TERM; other codes act as NOP.
- R1 (continued): The burst length comes from mode bits [2:0]: 000=1, 001=2, 010=4, 011=8, 111=full page (2^COL_W beats). A burst issues exactly that many beats, then `beat_o` falls.
- R2: Every beat stays inside the aligned block whose size equals the burst length. With mode bit 3 = 0 the in-block offset is (start offset + beat index) mod length. With bit 3 = 1 it is start offset XOR beat index. Beat 0 is in the cycle the command is presented.
- R3: Read latency m comes from mode bits [6:4] (1, 2 or 3). For a READ registered at edge n, word i appears on `rdata_o` with `rvalid_o` high after edge n+m+i.
- R4: `oe_o` rises after edge n+m-1, one cycle before the first valid word. It stays high through the last valid word and is low whenever no read word is due.
- R5: A reserved mode word raises `mode_err_o`. Reserved means any of: mode bits [8:7] not 00, a length code of 100/101/110, or a latency field outside 1..3. While the flag is up, READ and WRITE are ignored, so no beat, no write and no read data occur.
- R6: With mode bit 9 = 0, a write burst uses the read length. The exception is a full-page length, where a write burst is 8 beats within its aligned 8-word block.
- R7: With mode bit 9 = 1, every write is a single beat at the given address, while reads keep the programmed length.
- R8: TERM, or a new READ or WRITE, stops the current burst at that edge. Read words already issued are still delivered at their latency.
- R9: LOAD takes effect only when no burst beats remain and no read word is pending; otherwise it is ignored and the running burst continues. An accepted mode applies from the very next command.
- R10: On each write beat, `wdata_i` is stored at `col_o`. After reset the mode is length 1, sequential, latency 1, and `oe_o`, `rvalid_o`, `beat_o` and `mode_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code |
| addr_i | input | COL_W | Starting column for READ/WRITE |
| mode_i | input | 10 | Mode word, taken with LOAD |
| wdata_i | input | DW | Write data for the current write beat |
| beat_o | output | 1 | An access beat occurs at the coming edge |
| beat_wr_o | output | 1 | The current beat is a write |
| col_o | output | COL_W | Column of the current beat |
| oe_o | output | 1 | Data output enable |
| rvalid_o | output | 1 | Read word valid on rdata_o |
| rdata_o | output | DW | Read data |
| mode_err_o | output | 1 | Stored mode word is reserved |

## Verification
The bench builds the block with COL_W=5 and DW=16. The page is then 32 words, so a full-page read of 32 beats, wrapping from column 31 to 0, fits in a short run. The 8-beat cap on full-page writes is also clearly separate from the 32-beat read length. All three latency settings are driven, so the one-cycle lead of `oe_o` over `rvalid_o` is seen at each setting. The sequential and interleaved orders are compared at lengths 2, 4 and 8 with unaligned start columns.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int MODE_W  = 10;
  localparam int LAT_MAX = 3;
  localparam int LAT_W   = $clog2(LAT_MAX + 1);

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_LOAD  = 3'd3,
    CMD_TERM  = 3'd4
  } cmd_e;

  typedef struct packed {
    logic       wr_single;
    logic [1:0] op_mode;
    logic [2:0] lat;
    logic       interleave;
    logic [2:0] len_code;
  } mode_t;

  localparam mode_t MODE_RST = '{
    wr_single:  1'b0,
    op_mode:    2'b00,
    lat:        3'd1,
    interleave: 1'b0,
    len_code:   3'b000
  };

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 5,
  localparam int LG_W = $clog2(COL_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MODE_W-1:0] mode_i,
  output mode_t             mode_o,
  output logic [LG_W-1:0]   rd_lg_o,
  output logic [LG_W-1:0]   wr_lg_o,
  output logic              interleave_o,
  output logic [LAT_W-1:0]  lat_o,
  output logic              err_o
);

  mode_t mode_q;
  logic  len_bad, lat_bad, op_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= MODE_RST;
    else if (load_i) mode_q <= mode_t'(mode_i);
  end

  always_comb begin
    len_bad = 1'b0;
    unique case (mode_q.len_code)
      3'b000:  rd_lg_o = LG_W'(0);
      3'b001:  rd_lg_o = LG_W'(1);
      3'b010:  rd_lg_o = LG_W'(2);
      3'b011:  rd_lg_o = LG_W'(3);
      3'b111:  rd_lg_o = LG_W'(COL_W);
      default: begin
        rd_lg_o = LG_W'(0);
        len_bad = 1'b1;
      end
    endcase
    // write policy: single beat, or full page capped at 8
    if (mode_q.wr_single)                 wr_lg_o = LG_W'(0);
    else if (mode_q.len_code == 3'b111)   wr_lg_o = LG_W'(3);
    else                                  wr_lg_o = rd_lg_o;
    lat_bad = (mode_q.lat == 3'd0) || (int'(mode_q.lat) > LAT_MAX);
    op_bad  = (mode_q.op_mode != 2'b00);
  end

  assign err_o        = len_bad | lat_bad | op_bad;
  assign interleave_o = mode_q.interleave;
  assign lat_o        = mode_q.lat[LAT_W-1:0];
  assign mode_o       = mode_q;

  initial begin
    assert (COL_W >= 4) else $error("COL_W must exceed the 8-beat write cap");
  end

  AST_WR_NEVER_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o |-> (wr_lg_o <= LG_W'(3)));  // R6

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int COL_W = 5,
  localparam int LG_W  = $clog2(COL_W + 1),
  localparam int CNT_W = COL_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             kind_i,
  input  logic [COL_W-1:0] addr_i,
  input  logic [LG_W-1:0]  lg_i,
  input  logic             il_i,
  input  logic             stop_i,
  output logic             beat_o,
  output logic             kind_o,
  output logic [COL_W-1:0] col_o,
  output logic             active_o
);

  logic             act_q, kind_q, il_q;
  logic [LG_W-1:0]  lg_q;
  logic [COL_W-1:0] base_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] len_q;

  function automatic logic [COL_W-1:0] walk(
    input logic [COL_W-1:0] a,
    input logic [COL_W-1:0] i,
    input logic [LG_W-1:0]  lg,
    input logic             il
  );
    logic [COL_W-1:0] mask, low;
    mask = COL_W'((CNT_W'(1) << lg) - CNT_W'(1));
    low  = il ? (a ^ i) : (a + i);
    return (a & ~mask) | (low & mask);
  endfunction

  assign len_q = CNT_W'(1) << lg_q;

  always_comb begin
    beat_o = 1'b0;
    kind_o = kind_q;
    col_o  = base_q;
    if (start_i) begin
      beat_o = 1'b1;
      kind_o = kind_i;
      col_o  = addr_i;
    end else if (act_q && !stop_i) begin
      beat_o = 1'b1;
      col_o  = walk(base_q, idx_q[COL_W-1:0], lg_q, il_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      kind_q <= 1'b0;
      il_q   <= 1'b0;
      lg_q   <= '0;
      base_q <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      act_q  <= (lg_i != '0);
      kind_q <= kind_i;
      il_q   <= il_i;
      lg_q   <= lg_i;
      base_q <= addr_i;
      idx_q  <= CNT_W'(1);
    end else if (stop_i) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      idx_q <= idx_q + CNT_W'(1);
      if (idx_q + CNT_W'(1) == len_q) act_q <= 1'b0;
    end
  end

  assign active_o = act_q;

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (idx_q < len_q));  // R1

  AST_BEAT_IN_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o && !start_i) |-> (((col_o ^ base_q) & ~COL_W'(len_q - CNT_W'(1))) == '0));  // R2

endmodule

// File: rtl/burst_read_pipe.sv
module burst_read_pipe
  import burst_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [DW-1:0]    data_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             oe_o,
  output logic             rvalid_o,
  output logic [DW-1:0]    rdata_o,
  output logic             pending_o
);

  logic [LAT_MAX:1] vld_q;
  logic [DW-1:0]    dat_q [LAT_MAX:1];
  logic             lead, cur;
  logic [DW-1:0]    dsel;

  for (genvar k = 1; k <= LAT_MAX; k++) begin : g_stage
    if (k == 1) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[k] <= 1'b0;
          dat_q[k] <= '0;
        end else begin
          vld_q[k] <= issue_i;
          dat_q[k] <= data_i;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[k] <= 1'b0;
          dat_q[k] <= '0;
        end else begin
          vld_q[k] <= vld_q[k-1];
          dat_q[k] <= dat_q[k-1];
        end
      end
    end
  end

  // lead: word due one edge later; cur: word due now
  always_comb begin
    lead = issue_i;
    cur  = vld_q[1];
    dsel = dat_q[1];
    for (int k = 2; k <= LAT_MAX; k++) begin
      if (int'(lat_i) == k) begin
        lead = vld_q[k-1];
        cur  = vld_q[k];
        dsel = dat_q[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o     <= 1'b0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      oe_o     <= lead | cur;
      rvalid_o <= cur;
      if (cur) rdata_o <= dsel;
    end
  end

  assign pending_o = |vld_q;

  AST_OE_COVERS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> oe_o);  // R4

  AST_OE_LEADS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rvalid_o) |-> $past(oe_o));  // R4

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 5,
  parameter int DW    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [COL_W-1:0]  addr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              beat_o,
  output logic              beat_wr_o,
  output logic [COL_W-1:0]  col_o,
  output logic              oe_o,
  output logic              rvalid_o,
  output logic [DW-1:0]     rdata_o,
  output logic              mode_err_o
);

  localparam int DEPTH = 1 << COL_W;
  localparam int LG_W  = $clog2(COL_W + 1);

  mode_t            mode_q;
  logic [LG_W-1:0]  rd_lg, wr_lg;
  logic             il;
  logic [LAT_W-1:0] lat;
  logic             rd_go, wr_go, term, load_go, idle;
  logic             active, pending;
  logic [DW-1:0]    mem [DEPTH];

  assign rd_go   = (cmd_i == CMD_READ)  && !mode_err_o;
  assign wr_go   = (cmd_i == CMD_WRITE) && !mode_err_o;
  assign term    = (cmd_i == CMD_TERM);
  assign idle    = !active && !pending;
  assign load_go = (cmd_i == CMD_LOAD) && idle;

  burst_mode_reg #(.COL_W(COL_W)) u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_go),
    .mode_i       (mode_i),
    .mode_o       (mode_q),
    .rd_lg_o      (rd_lg),
    .wr_lg_o      (wr_lg),
    .interleave_o (il),
    .lat_o        (lat),
    .err_o        (mode_err_o)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (rd_go | wr_go),
    .kind_i   (wr_go),
    .addr_i   (addr_i),
    .lg_i     (wr_go ? wr_lg : rd_lg),
    .il_i     (il),
    .stop_i   (term),
    .beat_o   (beat_o),
    .kind_o   (beat_wr_o),
    .col_o    (col_o),
    .active_o (active)
  );

  always_ff @(posedge clk_i) begin
    if (beat_o && beat_wr_o) mem[col_o] <= wdata_i;
  end

  burst_read_pipe #(.DW(DW)) u_rpipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .issue_i   (beat_o && !beat_wr_o),
    .data_i    (mem[col_o]),
    .lat_i     (lat),
    .oe_o      (oe_o),
    .rvalid_o  (rvalid_o),
    .rdata_o   (rdata_o),
    .pending_o (pending)
  );

  AST_NO_ACCESS_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> !beat_o);  // R5

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_i == CMD_LOAD) && !idle) |=> $stable(mode_q));  // R9

  AST_WR_SINGLE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.wr_single && !wr_go) |-> !(beat_o && beat_wr_o));  // R7

endmodule

// File: tb/tb_burst_seq.sv
module tb_burst_seq;
  import burst_seq_pkg::*;

  localparam int COL_W = 5;
  localparam int DW    = 16;
  localparam int PAGE  = 1 << COL_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0]        cmd;
  logic [COL_W-1:0]  addr;
  logic [MODE_W-1:0] mode;
  logic [DW-1:0]     wdata;
  logic              beat_o, beat_wr_o, oe_o, rvalid_o, mode_err_o;
  logic [COL_W-1:0]  col_o;
  logic [DW-1:0]     rdata_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [DW-1:0] shadow [PAGE];

  always #10 clk_i = ~clk_i;

  burst_seq #(.COL_W(COL_W), .DW(DW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd), .addr_i(addr), .mode_i(mode),
    .wdata_i(wdata), .beat_o(beat_o), .beat_wr_o(beat_wr_o), .col_o(col_o),
    .oe_o(oe_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o), .mode_err_o(mode_err_o)
  );

  // {mode, start, len, eight 5-bit columns, first beat in the top field}
  localparam logic [58:0] VEC [8] = '{
    {10'h012, 5'd5,  4'd4, 5'd5,  5'd6,  5'd7,  5'd4,  20'd0},
    {10'h01A, 5'd5,  4'd4, 5'd5,  5'd4,  5'd7,  5'd6,  20'd0},
    {10'h013, 5'd11, 4'd8, 5'd11, 5'd12, 5'd13, 5'd14, 5'd15, 5'd8,  5'd9,  5'd10},
    {10'h01B, 5'd11, 4'd8, 5'd11, 5'd10, 5'd9,  5'd8,  5'd15, 5'd14, 5'd13, 5'd12},
    {10'h011, 5'd7,  4'd2, 5'd7,  5'd6,  30'd0},
    {10'h019, 5'd6,  4'd2, 5'd6,  5'd7,  30'd0},
    {10'h010, 5'd19, 4'd1, 5'd19, 35'd0},
    {10'h013, 5'd24, 4'd8, 5'd24, 5'd25, 5'd26, 5'd27, 5'd28, 5'd29, 5'd30, 5'd31}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #5;
  endtask

  function automatic logic [MODE_W-1:0] mk_mode(int lat, int len, int il, int wbm);
    logic [2:0] code;
    case (len)
      1: code = 3'b000;
      2: code = 3'b001;
      4: code = 3'b010;
      8: code = 3'b011;
      default: code = 3'b111;
    endcase
    return MODE_W'((wbm << 9) | (lat << 4) | (il << 3) | int'(code));
  endfunction

  function automatic int exp_col(int start, int len, int il, int j);
    int base, off;
    base = start - (start % len);
    off  = start % len;
    if (il != 0) return base + (off ^ j);
    return base + ((off + j) % len);
  endfunction

  task automatic load_mode(input logic [MODE_W-1:0] m);
    repeat (6) tick();
    cmd = CMD_LOAD;
    mode = m;
    tick();
    cmd = CMD_NOP;
  endtask

  task automatic read_chk(input int lat, input int start, input int len, input int il,
                          input int wbm, input string tag);
    load_mode(mk_mode(lat, len, il, wbm));
    cmd  = CMD_READ;
    addr = COL_W'(start);
    for (int e = 0; e <= lat + len; e++) begin
      tick();
      cmd = CMD_NOP;
      chk({tag, " R4 oe"}, 32'(oe_o), 32'((e >= lat - 1) && (e <= lat + len - 1)));
      chk({tag, " R3 rvalid"}, 32'(rvalid_o), 32'((e >= lat) && (e <= lat + len - 1)));
      if ((e >= lat) && (e <= lat + len - 1))
        chk({tag, " R3 rdata"}, 32'(rdata_o), 32'(shadow[exp_col(start, len, il, e - lat)]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    cmd = CMD_NOP; addr = '0; mode = '0; wdata = '0;
    repeat (3) @(posedge clk_i);
    #5;
    // R10 reset state
    chk("R10 reset oe", 32'(oe_o), 0);
    chk("R10 reset rvalid", 32'(rvalid_o), 0);
    chk("R10 reset beat", 32'(beat_o), 0);
    chk("R10 reset err", 32'(mode_err_o), 0);
    rst_ni = 1'b1;
    tick();
    chk("R10 after reset err", 32'(mode_err_o), 0);

    // R6: full-page write bursts are capped at 8 beats; fills the page (R10)
    load_mode(mk_mode(1, PAGE, 0, 0));
    for (int b = 0; b < PAGE / 8; b++) begin
      cmd  = CMD_WRITE;
      addr = COL_W'(b * 8);
      for (int j = 0; j < 9; j++) begin
        wdata = DW'(32'hA000 + b * 8 + j);
        #1;
        chk("R6 write beat", 32'(beat_o), 32'(j < 8));
        if (j < 8) begin
          chk("R6 write col", 32'(col_o), 32'(b * 8 + j));
          chk("R10 write kind", 32'(beat_wr_o), 1);
          shadow[b * 8 + j] = wdata;
        end
        tick();
        cmd = CMD_NOP;
      end
    end

    // vector table: burst orders (R1 length, R2 order)
    for (int v = 0; v < 8; v++) begin
      logic [58:0] vv;
      int len;
      vv  = VEC[v];
      len = int'(vv[43:40]);
      load_mode(vv[58:49]);
      cmd  = CMD_READ;
      addr = vv[48:44];
      for (int j = 0; j < len; j++) begin
        #1;
        chk("R1 beat active", 32'(beat_o), 1);
        chk("R2 column order", 32'(col_o), 32'(vv[39 - 5 * j -: 5]));
        tick();
        cmd = CMD_NOP;
      end
      #1;
      chk("R1 burst ends", 32'(beat_o), 0);
    end

    // R3/R4 all latencies, R10 read back of written data
    read_chk(1, 4, 4, 0, 0, "lat1");
    read_chk(2, 4, 4, 0, 0, "lat2");
    read_chk(3, 13, 8, 1, 0, "lat3 il");
    read_chk(2, 30, PAGE, 0, 0, "R1 full page R10");

    // R6: non-full write length follows read length
    load_mode(mk_mode(1, 4, 0, 0));
    cmd = CMD_WRITE;
    addr = 5'd20;
    for (int j = 0; j < 5; j++) begin
      wdata = DW'(32'hB000 + 20 + j);
      #1;
      chk("R6 BL4 write beat", 32'(beat_o), 32'(j < 4));
      if (j < 4) shadow[20 + j] = wdata;
      tick();
      cmd = CMD_NOP;
    end
    read_chk(2, 20, 4, 0, 0, "R6 readback");

    // R7: single-location writes, reads keep length
    load_mode(mk_mode(1, 4, 0, 1));
    cmd = CMD_WRITE;
    addr = 5'd9;
    wdata = 16'h5555;
    #1;
    chk("R7 single write beat", 32'(beat_o), 1);
    tick();
    cmd = CMD_NOP;
    #1;
    chk("R7 no second write beat", 32'(beat_o), 0);
    shadow[9] = 16'h5555;
    read_chk(1, 8, 4, 0, 1, "R7 read len");

    // R8: terminate keeps issued words
    load_mode(mk_mode(2, 8, 0, 0));
    cmd = CMD_READ;
    addr = 5'd16;
    tick();
    cmd = CMD_NOP;
    tick();
    tick();
    cmd = CMD_TERM;
    #1;
    chk("R8 term no beat", 32'(beat_o), 0);
    tick();
    cmd = CMD_NOP;
    chk("R8 word1 valid", 32'(rvalid_o), 1);
    chk("R8 word1 data", 32'(rdata_o), 32'(shadow[17]));
    tick();
    chk("R8 word2 valid", 32'(rvalid_o), 1);
    chk("R8 word2 data", 32'(rdata_o), 32'(shadow[18]));
    tick();
    chk("R8 after term rvalid", 32'(rvalid_o), 0);
    chk("R8 after term oe", 32'(oe_o), 0);
    #1;
    chk("R8 after term beat", 32'(beat_o), 0);

    // R8: new READ interrupts
    load_mode(mk_mode(1, 4, 0, 0));
    cmd = CMD_READ;
    addr = 5'd0;
    tick();
    cmd = CMD_NOP;
    #1;
    chk("R8 col1", 32'(col_o), 1);
    tick();
    cmd = CMD_READ;
    addr = 5'd20;
    #1;
    chk("R8 restart col", 32'(col_o), 20);
    tick();
    cmd = CMD_NOP;
    chk("R8 word1 before restart", 32'(rdata_o), 32'(shadow[1]));
    for (int j = 1; j < 4; j++) begin
      #1;
      chk("R8 restarted col", 32'(col_o), 32'(20 + j));
      tick();
    end
    #1;
    chk("R8 restarted end", 32'(beat_o), 0);

    // R5: reserved mode words
    load_mode(10'h090);
    chk("R5 op field err", 32'(mode_err_o), 1);
    cmd = CMD_READ;
    addr = 5'd0;
    #1;
    chk("R5 read ignored", 32'(beat_o), 0);
    tick();
    cmd = CMD_WRITE;
    addr = 5'd3;
    wdata = 16'hDEAD;
    #1;
    chk("R5 write ignored", 32'(beat_o), 0);
    tick();
    cmd = CMD_NOP;
    repeat (3) begin
      tick();
      chk("R5 oe stays low", 32'(oe_o), 0);
      chk("R5 rvalid stays low", 32'(rvalid_o), 0);
    end
    load_mode(10'h014);
    chk("R5 length code err", 32'(mode_err_o), 1);
    load_mode(10'h002);
    chk("R5 latency err", 32'(mode_err_o), 1);
    load_mode(10'h012);
    chk("R5 err cleared", 32'(mode_err_o), 0);
    read_chk(1, 0, 4, 0, 0, "R5 memory untouched");

    // R9: load while busy is ignored, burst runs on
    load_mode(mk_mode(1, 8, 0, 0));
    cmd = CMD_READ;
    addr = 5'd0;
    tick();
    cmd = CMD_LOAD;
    mode = mk_mode(1, 2, 0, 0);
    #1;
    chk("R9 burst continues", 32'(beat_o), 1);
    tick();
    cmd = CMD_NOP;
    for (int j = 2; j < 8; j++) begin
      #1;
      chk("R9 col during ignored load", 32'(col_o), 32'(j));
      tick();
    end
    repeat (5) tick();
    cmd = CMD_READ;
    addr = 5'd0;
    for (int j = 0; j < 8; j++) begin
      #1;
      chk("R9 mode kept beat", 32'(beat_o), 1);
      tick();
      cmd = CMD_NOP;
    end
    #1;
    chk("R9 mode kept end", 32'(beat_o), 0);

    // R9: accepted load applies to the next command
    load_mode(mk_mode(1, 2, 0, 0));
    cmd = CMD_READ;
    addr = 5'd5;
    #1;
    chk("R9 next cmd col0", 32'(col_o), 5);
    tick();
    cmd = CMD_NOP;
    #1;
    chk("R9 next cmd col1", 32'(col_o), 4);
    tick();
    #1;
    chk("R9 next cmd length", 32'(beat_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule